// File: doc/BRIEF.md
# Sleep-Mode Receive Descriptor Sequencer

This block stores received frames into a short, fixed list of buffer descriptors that software prepares before the system goes into a low-power state. Each descriptor gives a base address, a buffer length in bytes and a completion-interrupt flag. A pulse on the arm input copies the descriptor table and the number of valid descriptors into internal registers. From then on the table ports are not looked at again until the next accepted arm.

Received bytes come in with start, end and valid strobes. They go into a 64-entry receive FIFO. The sequencer drains the FIFO one byte per cycle and turns each byte into a byte-wide memory write inside the current descriptor's buffer. At the end of each frame it writes a status word back to that descriptor: the frame length and a truncation error bit. If the descriptor's flag is set, it also raises a one-cycle wakeup pulse.

When the last armed descriptor has been used, the channel pauses and stops draining. Further bytes pile up in the FIFO. Once the FIFO is full, new bytes are dropped and a sticky overrun flag is raised.

Top module: `rxSleepSeq`

## Requirements
- R1: After reset no descriptor is armed: `paused` is 1, `overrun` is 0, and `memWrEn`, `statWrEn` and `wakeup` are 0.
- R2: An accepted `armReq` pulse captures the three table ports and `armCount` and restarts at descriptor 0. A count above NUM_DESC is clamped to NUM_DESC. `paused` is 0 after the pulse whenever the clamped count is nonzero.
- R3: Each frame goes to its own descriptor, in index order 0, 1, 2 and so on. Byte k of a frame (k counted from 0 at the byte marked `rxSof`) is written with one `memWrEn` cycle at address base + k of that descriptor.
- R4: Bytes with k greater than or equal to the descriptor's length are not written. The descriptor's status then reports the error bit as 1.
- R5: The byte marked `rxEof` ends the frame. `statWrEn` is then high for one cycle, carrying the descriptor index on `statIdx`, the full frame length on `statLen` (truncated bytes included) and the error bit on `statErr`.
- R6: `wakeup` is high for one cycle together with the status write of a descriptor whose interrupt flag is 1. It is never high for a descriptor whose flag is 0.
- R7: After the frame in the last armed descriptor ends, `paused` becomes 1. The FIFO is no longer drained, and no memory or status write happens until the next accepted arm.
- R8: The receive FIFO holds 64 bytes. A byte that arrives while 64 are held is dropped and sets `overrun`. Filling the FIFO to exactly 64 bytes does not set it.
- R9: `overrun` stays 1 until `ovrClear` is pulsed, and then reads 0.
- R10: `armReq` is ignored while a frame is in progress, that is, after its start byte has been drained and before its end byte has been drained. Writes continue to the old descriptor, and the old descriptor count still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| armReq | input | 1 | Arm pulse: capture table and count |
| armCount | input | CNT_W (3) | Number of armed descriptors |
| tblBase | input | NUM_DESC*ADDR_W (64) | Base address per descriptor, entry i at [i*ADDR_W +: ADDR_W] |
| tblLen | input | NUM_DESC*LEN_W (48) | Buffer length per descriptor, entry i at [i*LEN_W +: LEN_W] |
| tblIrq | input | NUM_DESC (4) | Completion-interrupt flag per descriptor |
| rxValid | input | 1 | Received byte valid |
| rxSof | input | 1 | Byte is first of frame |
| rxEof | input | 1 | Byte is last of frame |
| rxData | input | 8 | Received byte |
| ovrClear | input | 1 | Clears the sticky overrun flag |
| memWrEn | output | 1 | Byte write request |
| memAddr | output | ADDR_W (16) | Byte write address |
| memData | output | 8 | Byte write data |
| statWrEn | output | 1 | Status write-back strobe |
| statIdx | output | IDX_W (2) | Descriptor receiving the status |
| statLen | output | LEN_W (12) | Frame length in bytes |
| statErr | output | 1 | Frame was truncated |
| wakeup | output | 1 | One-cycle wakeup pulse |
| paused | output | 1 | Channel paused, no descriptor left |
| overrun | output | 1 | Sticky FIFO overflow flag |

## Verification
The hardest condition to reach from the ports is overrun. It needs the descriptor list used up, and then exactly 64 bytes held in the FIFO before one more byte arrives. The stimulus first uses up all four descriptors with frames of known lengths. It then sends a five-byte frame that stays in the FIFO, followed by exactly 59 more bytes, and checks that the flag is still clear. One further byte must then set it. A second hard case is an arm pulse that lands inside a frame. The bench sends the start of a frame, waits until those bytes have been drained, pulses arm with a different table, and then finishes the frame. It checks that every address still points at the old buffer and that the channel pauses after the old count.

// File: rtl/rxSleepSeqPkg.sv
package rxSleepSeqPkg;
  typedef struct packed {
    logic loadTable;
    logic writeByte;
    logic frameStart;
    logic frameEnd;
  } seqStrobeT;
endpackage

// File: rtl/rxSleepFifo.sv
module rxSleepFifo #(
  parameter int DEPTH = 64,
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         pushValid,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  input  logic         ovrClear,
  output logic [W-1:0] headData,
  output logic         empty,
  output logic         overrun
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] fill;
  logic          full, push, doPop;

  assign full     = (fill == CW'(DEPTH));
  assign empty    = (fill == '0);
  assign push     = pushValid && !full;
  assign doPop    = pop && !empty;
  assign headData = store[rdPtr];

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fill    <= '0;
      overrun <= 1'b0;
    end else begin
      if (push)  wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop) rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({push, doPop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      if (pushValid && full) overrun <= 1'b1;
      else if (ovrClear)     overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/rxSleepCtrl.sv
module rxSleepCtrl
  import rxSleepSeqPkg::*;
#(
  parameter int NUM_DESC = 4,
  parameter int CNT_W = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             armReq,
  input  logic [CNT_W-1:0] armCount,
  input  logic             fifoEmpty,
  input  logic             headSof,
  input  logic             headEof,
  output logic             pop,
  output seqStrobeT        strobe,
  output logic [IDX_W-1:0] curIdx,
  output logic             paused
);
  logic [CNT_W-1:0] idxQ, cntQ, cntClamped;
  logic             inFrameQ, armTake;

  assign armTake    = armReq && !inFrameQ;
  assign cntClamped = (armCount > CNT_W'(NUM_DESC)) ? CNT_W'(NUM_DESC) : armCount;
  assign paused     = (idxQ == cntQ);
  assign pop        = !fifoEmpty && !paused && !armTake;
  assign curIdx     = IDX_W'(idxQ);

  always_comb begin
    strobe.loadTable  = armTake;
    strobe.writeByte  = pop && (inFrameQ || headSof);
    strobe.frameStart = pop && headSof;
    strobe.frameEnd   = pop && (inFrameQ || headSof) && headEof;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ     <= '0;
      cntQ     <= '0;
      inFrameQ <= 1'b0;
    end else if (armTake) begin
      idxQ     <= '0;
      cntQ     <= cntClamped;
      inFrameQ <= 1'b0;
    end else if (strobe.frameEnd) begin
      idxQ     <= idxQ + 1'b1;
      inFrameQ <= 1'b0;
    end else if (strobe.frameStart) begin
      inFrameQ <= 1'b1;
    end
  end
endmodule

// File: rtl/rxSleepDatapath.sv
module rxSleepDatapath
  import rxSleepSeqPkg::*;
#(
  parameter int NUM_DESC = 4,
  parameter int ADDR_W = 16,
  parameter int LEN_W = 12,
  parameter int IDX_W = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  seqStrobeT                  strobe,
  input  logic [IDX_W-1:0]           curIdx,
  input  logic [7:0]                 headByte,
  input  logic [NUM_DESC*ADDR_W-1:0] tblBase,
  input  logic [NUM_DESC*LEN_W-1:0]  tblLen,
  input  logic [NUM_DESC-1:0]        tblIrq,
  output logic                       memWrEn,
  output logic [ADDR_W-1:0]          memAddr,
  output logic [7:0]                 memData,
  output logic                       statWrEn,
  output logic [IDX_W-1:0]           statIdx,
  output logic [LEN_W-1:0]           statLen,
  output logic                       statErr,
  output logic                       wakeup
);
  logic [ADDR_W-1:0] baseQ [NUM_DESC];
  logic [LEN_W-1:0]  lenQ  [NUM_DESC];
  logic [NUM_DESC-1:0] irqQ;
  logic [LEN_W-1:0]  offQ, effOff, nextOff;
  logic              truncQ, inBuf, truncNow;

  for (genvar i = 0; i < NUM_DESC; i++) begin : g_tbl
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ[i] <= '0;
        lenQ[i]  <= '0;
        irqQ[i]  <= 1'b0;
      end else if (strobe.loadTable) begin
        baseQ[i] <= tblBase[i*ADDR_W +: ADDR_W];
        lenQ[i]  <= tblLen[i*LEN_W +: LEN_W];
        irqQ[i]  <= tblIrq[i];
      end
    end
  end

  assign effOff   = strobe.frameStart ? '0 : offQ;
  assign nextOff  = (&effOff) ? effOff : effOff + 1'b1;
  assign inBuf    = effOff < lenQ[curIdx];
  assign truncNow = (truncQ && !strobe.frameStart) || !inBuf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offQ     <= '0;
      truncQ   <= 1'b0;
      memWrEn  <= 1'b0;
      memAddr  <= '0;
      memData  <= '0;
      statWrEn <= 1'b0;
      statIdx  <= '0;
      statLen  <= '0;
      statErr  <= 1'b0;
      wakeup   <= 1'b0;
    end else begin
      memWrEn  <= strobe.writeByte && inBuf;
      memAddr  <= baseQ[curIdx] + ADDR_W'(effOff);
      memData  <= headByte;
      statWrEn <= strobe.frameEnd;
      statIdx  <= curIdx;
      statLen  <= nextOff;
      statErr  <= truncNow;
      wakeup   <= strobe.frameEnd && irqQ[curIdx];
      if (strobe.writeByte) begin
        offQ   <= nextOff;
        truncQ <= truncNow;
      end
    end
  end
endmodule

// File: rtl/rxSleepSeq.sv
module rxSleepSeq
  import rxSleepSeqPkg::*;
#(
  parameter int NUM_DESC = 4,
  parameter int ADDR_W = 16,
  parameter int LEN_W = 12,
  parameter int FIFO_DEPTH = 64,
  localparam int IDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int CNT_W = $clog2(NUM_DESC + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       armReq,
  input  logic [CNT_W-1:0]           armCount,
  input  logic [NUM_DESC*ADDR_W-1:0] tblBase,
  input  logic [NUM_DESC*LEN_W-1:0]  tblLen,
  input  logic [NUM_DESC-1:0]        tblIrq,
  input  logic                       rxValid,
  input  logic                       rxSof,
  input  logic                       rxEof,
  input  logic [7:0]                 rxData,
  input  logic                       ovrClear,
  output logic                       memWrEn,
  output logic [ADDR_W-1:0]          memAddr,
  output logic [7:0]                 memData,
  output logic                       statWrEn,
  output logic [IDX_W-1:0]           statIdx,
  output logic [LEN_W-1:0]           statLen,
  output logic                       statErr,
  output logic                       wakeup,
  output logic                       paused,
  output logic                       overrun
);
  logic [9:0]       headWord;
  logic             fifoEmpty, pop;
  seqStrobeT        strobe;
  logic [IDX_W-1:0] curIdx;

  rxSleepFifo #(.DEPTH(FIFO_DEPTH), .W(10)) fifo_i (
    .clk(clk), .rstN(rstN), .pushValid(rxValid),
    .pushData({rxSof, rxEof, rxData}), .pop(pop), .ovrClear(ovrClear),
    .headData(headWord), .empty(fifoEmpty), .overrun(overrun)
  );

  rxSleepCtrl #(.NUM_DESC(NUM_DESC), .CNT_W(CNT_W), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .armReq(armReq), .armCount(armCount),
    .fifoEmpty(fifoEmpty), .headSof(headWord[9]), .headEof(headWord[8]),
    .pop(pop), .strobe(strobe), .curIdx(curIdx), .paused(paused)
  );

  rxSleepDatapath #(.NUM_DESC(NUM_DESC), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
                    .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curIdx(curIdx),
    .headByte(headWord[7:0]), .tblBase(tblBase), .tblLen(tblLen),
    .tblIrq(tblIrq), .memWrEn(memWrEn), .memAddr(memAddr),
    .memData(memData), .statWrEn(statWrEn), .statIdx(statIdx),
    .statLen(statLen), .statErr(statErr), .wakeup(wakeup)
  );
endmodule

// File: rtl/rxSleepSeqChk.sv
module rxSleepSeqChk (
  input logic clk,
  input logic rstN,
  input logic armReq,
  input logic paused,
  input logic memWrEn,
  input logic statWrEn,
  input logic wakeup,
  input logic overrun,
  input logic ovrClear,
  input logic rxValid
);
  // R7: a paused channel, without a new arm, produces no writes next cycle
  assert_paused_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (paused && !armReq) |=> (!memWrEn && !statWrEn));

  // R9: overrun holds until cleared
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !ovrClear) |=> overrun);

  // R8: overrun only rises after an arriving byte
  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(rxValid));

  // R6: wakeup only accompanies a status write-back
  assert_wakeup_with_status_R6: assert property (@(posedge clk) disable iff (!rstN)
    wakeup |-> statWrEn);
endmodule

bind rxSleepSeq rxSleepSeqChk chk_i (
  .clk(clk), .rstN(rstN), .armReq(armReq), .paused(paused),
  .memWrEn(memWrEn), .statWrEn(statWrEn), .wakeup(wakeup),
  .overrun(overrun), .ovrClear(ovrClear), .rxValid(rxValid)
);

// File: tb/rxSleepSeq_tb_top.sv
module rxSleepSeq_tb_top;
  localparam int ND = 4;
  localparam int AW = 16;
  localparam int LW = 12;
  // frame length, buffer length, irq flag
  localparam int FR [4][3] = '{'{10, 16, 1}, '{20, 8, 0}, '{1, 4, 1}, '{6, 6, 0}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic armReq = 1'b0;
  logic [2:0] armCount = '0;
  logic [ND*AW-1:0] tblBase = '0;
  logic [ND*LW-1:0] tblLen = '0;
  logic [ND-1:0] tblIrq = '0;
  logic rxValid = 1'b0, rxSof = 1'b0, rxEof = 1'b0, ovrClear = 1'b0;
  logic [7:0] rxData = '0;
  logic memWrEn, statWrEn, statErr, wakeup, paused, overrun;
  logic [AW-1:0] memAddr;
  logic [7:0] memData;
  logic [1:0] statIdx;
  logic [LW-1:0] statLen;

  int checks = 0, errors = 0;
  int wrN = 0, stN = 0, wakeN = 0;
  logic [AW-1:0] wrAddr [1024];
  logic [7:0] wrData [1024];
  int stIdx [64], stLen [64], stErr [64], stWake [64];

  always #2 clk = ~clk;

  rxSleepSeq dut_i (
    .clk(clk), .rstN(rstN), .armReq(armReq), .armCount(armCount),
    .tblBase(tblBase), .tblLen(tblLen), .tblIrq(tblIrq),
    .rxValid(rxValid), .rxSof(rxSof), .rxEof(rxEof), .rxData(rxData),
    .ovrClear(ovrClear), .memWrEn(memWrEn), .memAddr(memAddr),
    .memData(memData), .statWrEn(statWrEn), .statIdx(statIdx),
    .statLen(statLen), .statErr(statErr), .wakeup(wakeup),
    .paused(paused), .overrun(overrun)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (memWrEn && wrN < 1024) begin
        wrAddr[wrN] = memAddr; wrData[wrN] = memData; wrN++;
      end
      if (statWrEn && stN < 64) begin
        stIdx[stN] = int'(statIdx); stLen[stN] = int'(statLen);
        stErr[stN] = int'(statErr); stWake[stN] = int'(wakeup); stN++;
      end
      if (wakeup) wakeN++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    wrN = 0; stN = 0; wakeN = 0;
  endtask

  task automatic arm(input int cnt);
    @(negedge clk); armReq = 1'b1; armCount = 3'(cnt);
    @(negedge clk); armReq = 1'b0;
  endtask

  task automatic sendBytes(input int n, input int first, input bit sof, input bit eof);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rxValid = 1'b1; rxSof = sof && (k == 0); rxEof = eof && (k == n - 1);
      rxData = 8'(first + k);
    end
    @(negedge clk); rxValid = 1'b0; rxSof = 1'b0; rxEof = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int w0, bad, expW, wakeExp;
    doReset();
    @(negedge clk);
    // R1 reset state
    check(paused == 1'b1, "R1", "paused", int'(paused), 1);
    check(overrun == 1'b0 && memWrEn == 1'b0 && statWrEn == 1'b0 && wakeup == 1'b0,
          "R1", "outputs idle", int'({overrun, memWrEn, statWrEn, wakeup}), 0);

    for (int i = 0; i < ND; i++) begin
      tblBase[i*AW +: AW] = AW'(16'h1000 * (i + 1));
      tblLen[i*LW +: LW] = LW'(FR[i][1]);
      tblIrq[i] = FR[i][2][0];
    end
    arm(4);
    check(paused == 1'b0, "R2", "paused after arm", int'(paused), 0);

    wakeExp = 0;
    for (int i = 0; i < ND; i++) begin
      w0 = wrN;
      sendBytes(FR[i][0], i * 32 + 3, 1'b1, 1'b1);
      repeat (6) @(negedge clk);
      expW = (FR[i][0] < FR[i][1]) ? FR[i][0] : FR[i][1];
      // R3/R4: byte writes of frame i
      check(wrN - w0 == expW, "R4", "write count", wrN - w0, expW);
      bad = 0;
      for (int k = 0; k < expW && w0 + k < wrN; k++)
        if (wrAddr[w0 + k] != AW'(16'h1000 * (i + 1) + k) ||
            wrData[w0 + k] != 8'(i * 32 + 3 + k)) bad++;
      check(bad == 0, "R3", "address/data mismatches", bad, 0);
      // R5 status write-back
      check(stN == i + 1, "R5", "status count", stN, i + 1);
      if (stN == i + 1) begin
        check(stIdx[i] == i && stLen[i] == FR[i][0], "R5", "status idx/len",
              stIdx[i] * 10000 + stLen[i], i * 10000 + FR[i][0]);
        check(stErr[i] == int'(FR[i][0] > FR[i][1]), "R4", "status err",
              stErr[i], int'(FR[i][0] > FR[i][1]));
        check(stWake[i] == FR[i][2], "R6", "wakeup with status", stWake[i], FR[i][2]);
      end
      wakeExp += FR[i][2];
      check(wakeN == wakeExp, "R6", "wakeup cycles", wakeN, wakeExp);
    end

    // R7 paused after last descriptor, nothing drained
    check(paused == 1'b1, "R7", "paused after list used", int'(paused), 1);
    w0 = wrN;
    sendBytes(5, 200, 1'b1, 1'b1);
    repeat (6) @(negedge clk);
    check(wrN == w0 && stN == ND, "R7", "writes while paused", wrN - w0 + stN, ND);

    // R8 fill FIFO to exactly 64, then one more
    sendBytes(59, 0, 1'b0, 1'b0);
    check(overrun == 1'b0, "R8", "overrun at 64 bytes", int'(overrun), 0);
    sendBytes(1, 0, 1'b0, 1'b0);
    check(overrun == 1'b1, "R8", "overrun at 65th byte", int'(overrun), 1);
    repeat (4) @(negedge clk);
    check(overrun == 1'b1, "R9", "overrun sticky", int'(overrun), 1);
    @(negedge clk); ovrClear = 1'b1;
    @(negedge clk); ovrClear = 1'b0;
    check(overrun == 1'b0, "R9", "overrun cleared", int'(overrun), 0);

    // R10 arm during a frame is ignored
    doReset();
    tblBase[0 +: AW] = 16'h2000; tblLen[0 +: LW] = 12'd32; tblIrq = '0;
    arm(1);
    sendBytes(3, 8'h40, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    for (int i = 0; i < ND; i++) tblBase[i*AW +: AW] = AW'(16'h3000 + 16'h100 * i);
    arm(3);
    sendBytes(3, 8'h43, 1'b0, 1'b1);
    repeat (6) @(negedge clk);
    bad = 0;
    for (int k = 0; k < wrN; k++)
      if (wrAddr[k] != AW'(16'h2000 + k) || wrData[k] != 8'(8'h40 + k)) bad++;
    check(wrN == 6 && bad == 0, "R10", "writes stay in old buffer", wrN * 100 + bad, 600);
    check(paused == 1'b1, "R10", "old count kept", int'(paused), 1);

    // R2 clamp: count 7 acts as 4
    for (int i = 0; i < ND; i++) tblLen[i*LW +: LW] = 12'd8;
    arm(7);
    check(paused == 1'b0, "R2", "arm accepted when idle", int'(paused), 0);
    for (int i = 0; i < ND; i++) begin
      sendBytes(2, i * 4, 1'b1, 1'b1);
      repeat (4) @(negedge clk);
    end
    check(paused == 1'b1, "R2", "clamped count pauses after 4", int'(paused), 1);
    check(stN == 5 && stIdx[4] == 3, "R2", "status count/last idx", stN * 10 + stIdx[4], 53);
    check(wrN == 14 && wrAddr[12] == 16'h3300, "R3", "writes into new table",
          int'(wrAddr[12]), 16'h3300);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule